// File: doc/BRIEF.md
# Shadowed Converter Configuration Register Bank

This block is the register back end of a two-channel data converter that is programmed over a serial port. An upstream shifter has already turned the serial stream into byte-wide accesses: an address, a write strobe with a data byte, and a read strobe. The bank holds a small set of global and per-channel configuration registers and decodes them into control outputs. These outputs are the power state of each channel, the duty-cycle stabilizer enable, the clock divide ratio and the shift-order flag.

Configuration registers are double-buffered. A write only changes a shadow copy. A channel-select mask decides which channel's shadow copy a per-channel write reaches. Nothing reaches the outputs until software writes the commit register, which copies every shadow copy into its active copy on a single clock edge. Both channels therefore change together.

The port configuration register is different. It acts at once and holds each of its flags in two bit positions that mirror each other, so a byte shifted in either bit order decodes the same way. Setting its soft-reset flag returns the whole bank to its power-on values.

Top module: `cfg_shadow_bank`

## Requirements
- R1: `rd_data` is loaded at the rising edge where `rd_en` is sampled high and holds its value otherwise. Any address other than 0x00, 0x01, 0x02, 0x05, 0x08, 0x09, 0x0B and 0xFF reads 0x00, and writes to such addresses change no register or output.
- R2: After reset, 0x00 reads 0x18, 0x05 reads 0x03, and 0x08, 0x09, 0x0B and 0xFF read 0x00. Each channel's power state is 00 (run), `dcs_en_o` is 0, `clk_div_ratio_o` is 1 and `lsb_first_o` is 0.
- R3: Address 0x01 always reads the identifier 0x23, and writes to it have no effect.
- R4: Address 0x02 always reads 0x10, which is grade code 001 in bits 6:4. Writes to it have no effect.
- R5: A write to 0x00 sets the shift-order flag to (bit 6 OR bit 1) and takes effect at once on `lsb_first_o`. The register reads back with the flag in bits 6 and 1, the soft-reset flag in bits 5 and 2, ones in bits 4 and 3, and zeros in bits 7 and 0.
- R6: A write to 0x00 with bit 5 or bit 2 set starts a soft reset. One cycle after the write edge, every register, shadow and active, is back at its R2 value, and the soft-reset flag has cleared.
- R7: Writes to 0x08, 0x09 and 0x0B change only shadow copies. The outputs do not change until a commit.
- R8: A write to 0xFF with bit 0 set copies every shadow copy to its active copy at that edge, so the outputs show the new values from the next cycle. A write to 0xFF with bit 0 clear does nothing.
- R9: A write to 0x08 reaches channel A's shadow copy only if bit 0 of 0x05 is set, and channel B's only if bit 1 is set. Bits 1:0 of 0x05 are stored and read back.
- R10: A read of 0x08 returns the shadow copy of channel B when 0x05 selects only channel B, and channel A's shadow copy otherwise. The byte carries bits 7, 5 and 1:0, and all other bits are 0.
- R11: Writes to 0x09 and 0x0B reach the single global copy whatever 0x05 holds.
- R12: Each channel's two-bit slice of `pwr_state_o` (channel A in bits 1:0) shows bits 1:0 of its active 0x08 value: 00 run, 01 full power-down, 10 standby, 11 digital reset.
- R13: When bit 7 of a channel's active 0x08 value is set and `pdwn_pin` is high, that channel's state is 01 if bit 5 is 0 and 10 if bit 5 is 1. The pin acts combinationally.
- R14: `dcs_en_o` is bit 0 of the active 0x09 value. `clk_div_ratio_o` is bits 2:0 of the active 0x0B value plus 1, giving 1 to 8. Reads of 0x09 and 0x0B return only those bits of the shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Register address of the current access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered |
| pdwn_pin | input | 1 | External power-down pin |
| lsb_first_o | output | 1 | Shift-order flag for the serial front end |
| dcs_en_o | output | 1 | Duty-cycle stabilizer enable |
| clk_div_ratio_o | output | 4 | Clock divide ratio, 1 to 8 |
| pwr_state_o | output | 4 | Power state per channel, channel A in bits 1:0 |

## Verification
A shadow copy that leaks into its active copy shows up on the outputs in the cycle after the write, before any commit. A commit that misses a register leaves a stale output in the cycle after the commit write. A wrong channel mask or read selector shows up on the very next read of 0x08, so per-channel value sweeps under every mask catch it within two accesses. A soft reset that misses a register is visible one cycle after the reset write, either on the outputs or on the read sweep that follows.

// File: rtl/cfg_bank_pkg.sv
// Package: shared address map, power-mode encoding and per-channel record
// for the shadowed configuration bank.
// Assumes 8-bit addresses and 8-bit data on the byte access side.
package cfg_bank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_PORT   = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_IDENT  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_GRADE  = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_CHSEL  = 8'h05;
    localparam logic [ADDR_W-1:0] ADR_PWR    = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_DCS    = 8'h09;
    localparam logic [ADDR_W-1:0] ADR_CLKDIV = 8'h0B;
    localparam logic [ADDR_W-1:0] ADR_COMMIT = 8'hFF;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'b00,
        PWR_OFF  = 2'b01,
        PWR_STBY = 2'b10,
        PWR_DRST = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic      pin_en;
        logic      pin_stby;
        pwr_mode_e mode;
    } chan_cfg_t;

    localparam chan_cfg_t CHAN_CFG_RST = '{pin_en: 1'b0, pin_stby: 1'b0, mode: PWR_RUN};

endpackage

// File: rtl/cfg_port_reg.sv
// Module: immediate-effect port configuration register.
// Stores the shift-order and soft-reset flags, each taken as the OR of its
// two mirrored bit positions. The soft-reset flag clears itself one cycle
// after it is set, because a set flag drives the bank-wide clear.
// Assumes the caller decodes the address into wr_hit.
module cfg_port_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [6:1] wr_bits,
    output logic       lsb_first,
    output logic       soft_rst,
    output logic [7:0] rd_val
);

    // Flag storage: a set soft-reset flag clears everything on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lsb_first <= 1'b0;
            soft_rst  <= 1'b0;
        end else if (wr_hit) begin
            lsb_first <= wr_bits[6] | wr_bits[1];
            soft_rst  <= wr_bits[5] | wr_bits[2];
        end
    end

    // Mirrored read image, symmetric under bit reversal.
    always_comb begin
        rd_val = {1'b0, lsb_first, soft_rst, 2'b11, soft_rst, lsb_first, 1'b0};
    end

    assert_srst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!soft_rst && !lsb_first));

endmodule

// File: rtl/cfg_chan_slice.sv
// Module: one channel's power-mode register as a shadow/active pair.
// The shadow copy takes masked writes; the active copy loads the shadow copy
// on commit. clr is the bank-wide soft reset and wins over everything.
// Assumes wr_hit is already qualified by address and by the channel mask.
module cfg_chan_slice
    import cfg_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      wr_hit,
    input  chan_cfg_t wr_val,
    input  logic      commit,
    output chan_cfg_t shadow,
    output chan_cfg_t active
);

    // Shadow copy: written only when this channel is selected.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shadow <= CHAN_CFG_RST;
        end else if (wr_hit) begin
            shadow <= wr_val;
        end
    end

    // Active copy: loaded from the shadow copy on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active <= CHAN_CFG_RST;
        end else if (commit) begin
            active <= shadow;
        end
    end

    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr) |=> $stable(active));

    assert_commit_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clr) |=> (active == $past(shadow)));

    assert_masked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !clr) |=> $stable(shadow));

endmodule

// File: rtl/cfg_glob_reg.sv
// Module: global stabilizer-enable and clock-divider registers as
// shadow/active pairs. Writes are not masked by the channel selection.
// Assumes the caller decodes the two write hits.
module cfg_glob_reg #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_dcs,
    input  logic             wr_div,
    input  logic [DIV_W-1:0] wr_bits,
    input  logic             commit,
    output logic             dcs_shadow,
    output logic [DIV_W-1:0] div_shadow,
    output logic             dcs_active,
    output logic [DIV_W-1:0] div_active
);

    // Shadow copies: updated by their own address hits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dcs_shadow <= 1'b0;
            div_shadow <= '0;
        end else begin
            if (wr_dcs) dcs_shadow <= wr_bits[0];
            if (wr_div) div_shadow <= wr_bits;
        end
    end

    // Active copies: loaded on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dcs_active <= 1'b0;
            div_active <= '0;
        end else if (commit) begin
            dcs_active <= dcs_shadow;
            div_active <= div_shadow;
        end
    end

    assert_glob_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr) |=> ($stable(dcs_active) && $stable(div_active)));

    assert_glob_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clr) |=> (div_active == $past(div_shadow) && dcs_active == $past(dcs_shadow)));

endmodule

// File: rtl/cfg_shadow_bank.sv
// Module: top of the shadowed configuration bank. Decodes byte accesses,
// holds the channel-select mask, generates one power-mode slice per channel,
// forms the registered read data and resolves the control outputs.
// Assumes at most one access per cycle and NUM_CH <= 8.
module cfg_shadow_bank
    import cfg_bank_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter int          DIV_W   = 3,
    parameter logic [7:0]  CHIP_ID = 8'h23,
    parameter logic [2:0]  GRADE   = 3'b001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  pdwn_pin,
    output logic                  lsb_first_o,
    output logic                  dcs_en_o,
    output logic [DIV_W:0]        clk_div_ratio_o,
    output logic [2*NUM_CH-1:0]   pwr_state_o
);

    localparam logic [NUM_CH-1:0] CHSEL_RST = '1;
    localparam logic [7:0]        GRADE_IMG = {1'b0, GRADE, 4'b0000};

    logic                  soft_rst;
    logic [7:0]            port_img;
    logic [NUM_CH-1:0]     chsel;
    logic                  commit;
    logic                  wr_port, wr_chsel, wr_pwr, wr_dcs, wr_div;
    chan_cfg_t             wr_chan;
    chan_cfg_t             shadow [NUM_CH];
    chan_cfg_t             active [NUM_CH];
    chan_cfg_t             rd_chan;
    logic                  dcs_shadow, dcs_active;
    logic [DIV_W-1:0]      div_shadow, div_active;
    logic [DATA_W-1:0]     rd_next;

    // Write decode: soft reset blocks every write for its one cycle.
    always_comb begin
        wr_port  = wr_en && !soft_rst && (addr == ADR_PORT);
        wr_chsel = wr_en && !soft_rst && (addr == ADR_CHSEL);
        wr_pwr   = wr_en && !soft_rst && (addr == ADR_PWR);
        wr_dcs   = wr_en && !soft_rst && (addr == ADR_DCS);
        wr_div   = wr_en && !soft_rst && (addr == ADR_CLKDIV);
        commit   = wr_en && !soft_rst && (addr == ADR_COMMIT) && wr_data[0];
        wr_chan  = '{pin_en: wr_data[7], pin_stby: wr_data[5],
                     mode: pwr_mode_e'(wr_data[1:0])};
    end

    cfg_port_reg u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_port),
        .wr_bits   (wr_data[6:1]),
        .lsb_first (lsb_first_o),
        .soft_rst  (soft_rst),
        .rd_val    (port_img)
    );

    // Channel-select mask: acts immediately, not shadowed.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            chsel <= CHSEL_RST;
        end else if (wr_chsel) begin
            chsel <= wr_data[NUM_CH-1:0];
        end
    end

    // One shadow/active slice and one power resolver per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        cfg_chan_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (soft_rst),
            .wr_hit (wr_pwr && chsel[ch]),
            .wr_val (wr_chan),
            .commit (commit),
            .shadow (shadow[ch]),
            .active (active[ch])
        );

        // Pin override when enabled, otherwise the committed mode.
        always_comb begin
            if (active[ch].pin_en && pdwn_pin) begin
                pwr_state_o[2*ch +: 2] = active[ch].pin_stby ? PWR_STBY : PWR_OFF;
            end else begin
                pwr_state_o[2*ch +: 2] = active[ch].mode;
            end
        end
    end

    cfg_glob_reg #(.DIV_W(DIV_W)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .wr_dcs     (wr_dcs),
        .wr_div     (wr_div),
        .wr_bits    (wr_data[DIV_W-1:0]),
        .commit     (commit),
        .dcs_shadow (dcs_shadow),
        .div_shadow (div_shadow),
        .dcs_active (dcs_active),
        .div_active (div_active)
    );

    // Global control outputs from the active copies.
    always_comb begin
        dcs_en_o        = dcs_active;
        clk_div_ratio_o = {1'b0, div_active} + 1'b1;
    end

    // Per-channel read source: lowest selected channel, channel 0 if none.
    always_comb begin
        rd_chan = shadow[0];
        for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
            if (chsel[ch]) rd_chan = shadow[ch];
        end
    end

    // Read multiplexer over the supported address map.
    always_comb begin
        rd_next = '0;
        unique case (addr)
            ADR_PORT:   rd_next = port_img;
            ADR_IDENT:  rd_next = CHIP_ID;
            ADR_GRADE:  rd_next = GRADE_IMG;
            ADR_CHSEL:  rd_next[NUM_CH-1:0] = chsel;
            ADR_PWR:    rd_next = {rd_chan.pin_en, 1'b0, rd_chan.pin_stby, 3'b000, rd_chan.mode};
            ADR_DCS:    rd_next[0] = dcs_shadow;
            ADR_CLKDIV: rd_next[DIV_W-1:0] = div_shadow;
            default:    rd_next = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_IDENT) |=> (rd_data == CHIP_ID));

    assert_grade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_GRADE) |=> (rd_data == GRADE_IMG));

    assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_srst_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (chsel == CHSEL_RST && clk_div_ratio_o == 1 && !dcs_en_o));

endmodule

// File: tb/tb_cfg_shadow_bank.sv
module tb_cfg_shadow_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       pdwn_pin = 1'b0;
    logic       lsb_first_o;
    logic       dcs_en_o;
    logic [3:0] clk_div_ratio_o;
    logic [3:0] pwr_state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model (bench-side): shadow/active images.
    logic [7:0] m_sh [2];
    logic [7:0] m_act [2];
    logic [1:0] m_sel;
    logic [7:0] m_dcs_sh, m_dcs_act, m_div_sh, m_div_act;

    always #4 clk = ~clk;

    cfg_shadow_bank dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr            (addr),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .rd_en           (rd_en),
        .rd_data         (rd_data),
        .pdwn_pin        (pdwn_pin),
        .lsb_first_o     (lsb_first_o),
        .dcs_en_o        (dcs_en_o),
        .clk_div_ratio_o (clk_div_ratio_o),
        .pwr_state_o     (pwr_state_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_sh[0] = 0; m_sh[1] = 0; m_act[0] = 0; m_act[1] = 0;
        m_sel = 2'b11; m_dcs_sh = 0; m_dcs_act = 0; m_div_sh = 0; m_div_act = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [7:0] exp_default(input logic [7:0] a);
        case (a)
            8'h00:   return 8'h18;
            8'h01:   return 8'h23;
            8'h02:   return 8'h10;
            8'h05:   return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit supported(input logic [7:0] a);
        return a inside {8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'h0B, 8'hFF};
    endfunction

    function automatic logic [1:0] exp_state(input logic [7:0] v, input logic pin);
        if (v[7] && pin) return v[5] ? 2'b10 : 2'b01;
        return v[1:0];
    endfunction

    function automatic logic [3:0] exp_pwr(input logic pin);
        return {exp_state(m_act[1], pin), exp_state(m_act[0], pin)};
    endfunction

    task automatic chk_outputs(input string req);
        chk(req, pwr_state_o, exp_pwr(pdwn_pin));
        chk(req, dcs_en_o, m_dcs_act[0]);
        chk(req, clk_div_ratio_o, {1'b0, m_div_act[2:0]} + 4'd1);
    endtask

    task automatic commit_model();
        m_act[0] = m_sh[0]; m_act[1] = m_sh[1];
        m_dcs_act = m_dcs_sh; m_div_act = m_div_sh;
    endtask

    task automatic sweep_defaults(input string req);
        logic [7:0] d;
        for (int a = 0; a < 256; a++) begin
            rd(a[7:0], d);
            chk(req, d, exp_default(a[7:0]));
        end
    endtask

    task automatic do_soft_reset(input logic [7:0] v);
        wr(8'h00, v);
        @(negedge clk);
        model_reset();
        chk("R6 outputs", {lsb_first_o, pwr_state_o, dcs_en_o, clk_div_ratio_o},
            {1'b0, 4'b0000, 1'b0, 4'd1});
        sweep_defaults("R6 readback");
    endtask

    initial begin
        logic [7:0] d;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset outputs and read sweep, covering R1, R3 and R4 addresses.
        chk("R2 lsb", lsb_first_o, 1'b0);
        chk_outputs("R2 outputs");
        sweep_defaults("R2 R1 reset readback");

        // R1: writes to unsupported addresses leave everything untouched.
        for (int a = 0; a < 256; a++) begin
            if (!supported(a[7:0])) wr(a[7:0], 8'hFF);
        end
        chk_outputs("R1 outputs after unsupported writes");
        sweep_defaults("R1 readback after unsupported writes");

        // R1: rd_data holds while rd_en is low.
        rd(8'h01, d);
        @(negedge clk); addr = 8'h00; @(negedge clk);
        chk("R1 hold", rd_data, 8'h23);

        // R3 / R4: read-only registers ignore writes.
        wr(8'h01, 8'h00); wr(8'h02, 8'hFF);
        rd(8'h01, d); chk("R3 ident", d, 8'h23);
        rd(8'h02, d); chk("R4 grade", d, 8'h10);

        // R5: mirrored shift-order flag from either bit position.
        wr(8'h00, 8'h02); chk("R5 lsb via bit1", lsb_first_o, 1'b1);
        rd(8'h00, d);     chk("R5 image", d, 8'h5A);
        wr(8'h00, 8'h00); chk("R5 cleared", lsb_first_o, 1'b0);
        wr(8'h00, 8'h40); chk("R5 lsb via bit6", lsb_first_o, 1'b1);
        rd(8'h00, d);     chk("R5 image", d, 8'h5A);
        wr(8'h00, 8'h99); rd(8'h00, d); chk("R5 other bits ignored", d, 8'h18);

        // R11 R14 R7 R8: global sweep under every channel mask.
        for (int v = 0; v < 256; v++) begin
            m_sel = v[1:0];
            wr(8'h05, {6'b0, m_sel});
            wr(8'h0B, v[7:0]); m_div_sh = {5'b0, v[2:0]};
            wr(8'h09, v[7:0] ^ 8'h5C); m_dcs_sh = {7'b0, v[0] ^ 1'b0};
            chk_outputs("R7 global shadow isolation");
            rd(8'h0B, d); chk("R11 R14 divider readback", d, m_div_sh);
            rd(8'h09, d); chk("R11 R14 stabilizer readback", d, m_dcs_sh);
            if (v % 8 == 3) begin
                wr(8'hFF, 8'hFE);
                chk_outputs("R8 commit with bit0 clear");
            end
            wr(8'hFF, 8'h01); commit_model();
            chk_outputs("R8 R14 after commit");
        end
        rd(8'h05, d); chk("R9 mask readback", d, {6'b0, m_sel});

        // R9 R10 R12 R13 R7: per-channel sweep under every mask.
        for (int v = 0; v < 256; v++) begin
            m_sel = v[3:2] ^ v[1:0];
            wr(8'h05, {6'b0, m_sel});
            wr(8'h08, v[7:0]);
            if (m_sel[0]) m_sh[0] = v[7:0] & 8'hA3;
            if (m_sel[1]) m_sh[1] = v[7:0] & 8'hA3;
            chk_outputs("R7 channel shadow isolation");
            rd(8'h08, d);
            chk("R9 R10 channel readback", d, (m_sel == 2'b10) ? m_sh[1] : m_sh[0]);
            wr(8'hFF, 8'h01); commit_model();
            chk("R12 power state", pwr_state_o, exp_pwr(1'b0));
            @(negedge clk); pdwn_pin = 1'b1; #1;
            chk("R13 pin override", pwr_state_o, exp_pwr(1'b1));
            @(negedge clk); pdwn_pin = 1'b0; #1;
            chk("R12 pin released", pwr_state_o, exp_pwr(1'b0));
        end

        // R10: explicit selections and empty mask.
        m_sel = 2'b01; wr(8'h05, 8'h01); wr(8'h08, 8'h02); m_sh[0] = 8'h02;
        m_sel = 2'b10; wr(8'h05, 8'h02); wr(8'h08, 8'hA1); m_sh[1] = 8'hA1;
        rd(8'h08, d); chk("R10 B only", d, 8'hA1);
        wr(8'h05, 8'h03); rd(8'h08, d); chk("R10 both selects A", d, 8'h02);
        wr(8'h05, 8'h00); wr(8'h08, 8'h83);
        rd(8'h08, d); chk("R9 empty mask write ignored", d, 8'h02);
        wr(8'h05, 8'h02); rd(8'h08, d); chk("R9 empty mask B untouched", d, 8'hA1);

        // R6: soft reset through either mirrored bit.
        wr(8'h0B, 8'h05); wr(8'h09, 8'h01); wr(8'hFF, 8'h01);
        do_soft_reset(8'h20);
        wr(8'h00, 8'h40); wr(8'h05, 8'h01); wr(8'h08, 8'h03); wr(8'hFF, 8'h01);
        do_soft_reset(8'h04);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule